// File: doc/BRIEF.md
# Event Performance Counter Unit

This block counts hardware events for profiling. It holds two programmable event counters and one dedicated cycle counter, each 32 bits wide. One control word holds the global run bit, the clear strobes, the cycle-counter divide select, the per-counter interrupt enables, the per-counter overflow flags and the event codes of the two programmable counters. A flat register port addresses the control word and the three counters by a 2-bit index. Writes take effect at the clock edge. Reads are combinational.

Events arrive as a vector of single-cycle pulses, one line per event code, plus one external signal. A programmable counter cannot be gated on its own. It is parked by selecting the external-signal code while that signal is held low. Every counter wraps silently and raises its own sticky flag when it wraps. A single registered interrupt line combines the flags whose interrupt enable is set. Software reads the flags to find which counter caused the interrupt.

Top module: `pmu_unit`

## Requirements
- R1: After reset, all four registers read 0 and `irq` is 0.
- R2: The control word layout is as follows. Bit 0 is the run bit and bit 3 is the divide select. Bits 6:4 are the interrupt enables, with bit 4 for counter 0, bit 5 for counter 1 and bit 6 for the cycle counter. Bits 27:20 are the event code of counter 0 and bits 19:12 the event code of counter 1. Bits 10:8 are the overflow flags, in the same counter order. Bits 7, 11 and 31:28 always read 0.
- R3: A programmable counter adds 1 in a cycle when its code selects an event that is active in that cycle. Codes 0x00 to 0x12, except 0x08 and 0x0E, select `evt_in[code]`. Code 0x20 selects `ext_sig`. Code 0xFF selects every cycle. All other codes never count.
- R4: While the run bit is 0, no counter changes except through a register write or a clear strobe.
- R5: The cycle counter has no event code. It adds 1 on every cycle while the run bit is set. With the divide select set, it adds 1 once every 64 running cycles instead. The step comes from a 6-bit prescaler that advances on every running cycle and restarts when the cycle-counter clear strobe acts.
- R6: A counter that increments from 0xFFFFFFFF becomes 0 and sets its overflow flag at the same edge.
- R7: A control write that has 1 in a flag bit clears that flag. A 0 in a flag bit leaves the flag unchanged. If a clear and a new wrap of the same counter fall in the same cycle, the flag stays set.
- R8: `irq` is a register. It goes high one cycle after some flag is 1 while its interrupt enable is 1, and low one cycle after no such pair remains.
- R9: Bit 1 of the control word clears both programmable counters and bit 2 clears the cycle counter and its prescaler. A 1 written to either bit reads back as 1 for one cycle. During that cycle the clear acts, and the bit then returns to 0.
- R10: The counters are registers 1 to 3 of the register map. A write to a counter loads the written value, and it takes precedence over an increment in the same cycle. Writing 0 resets that one counter.
- R11: The register index selects the register: 0 is the control word, 1 the cycle counter, 2 counter 0 and 3 counter 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_idx | input | 2 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| evt_in | input | 19 | Event pulses, one line per event code 0x00 to 0x12 |
| ext_sig | input | 1 | External signal counted by code 0x20 |
| irq | output | 1 | Combined overflow interrupt |

## Verification
Pseudo-random pulses on every event line are applied while the counters select instruction, branch and top-of-range codes. Matching counts against a model show that the right line feeds each counter. The undefined codes and a code just above the range are driven with the same traffic and must stay at zero. Code 0x20 is run once with `ext_sig` toggling and once with it held low, which separates counting from parking. Writes are placed near 0xFFFFFFFF so that wraps land next to a flag clear. The divide and clear strobes are run against a free-running cycle counter, which exposes any off-by-one in the prescaler.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int CNT_W   = 32;
    localparam int SEL_W   = 8;
    localparam int NUM_EVT = 19;
    localparam int NUM_CTR = 3;
    localparam int NUM_PRG = 2;
    localparam int PRE_W   = 6;
    localparam int IDX_W   = 2;
    localparam int EIDX_W  = $clog2(NUM_EVT);

    // control word bit positions (software-visible layout)
    localparam int B_EN       = 0;
    localparam int B_RST_PROG = 1;
    localparam int B_RST_CYC  = 2;
    localparam int B_DIV      = 3;
    localparam int B_IEN      = 4;
    localparam int B_OVF      = 8;
    localparam int B_SEL1     = 12;
    localparam int B_SEL0     = 20;

    // counter slot order inside ien/ovf vectors
    localparam int SLOT_CYC = 2;

    localparam logic [SEL_W-1:0] CODE_EXT    = 8'h20;
    localparam logic [SEL_W-1:0] CODE_CYCLES = 8'hFF;
    localparam logic [SEL_W-1:0] CODE_HOLE_A = 8'h08;
    localparam logic [SEL_W-1:0] CODE_HOLE_B = 8'h0E;

    typedef enum logic [IDX_W-1:0] {
        REG_CTRL  = 2'd0,
        REG_CYC   = 2'd1,
        REG_PROG0 = 2'd2,
        REG_PROG1 = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [SEL_W-1:0]   sel0;
        logic [SEL_W-1:0]   sel1;
        logic [NUM_CTR-1:0] ovf;
        logic [NUM_CTR-1:0] ien;
        logic               div;
        logic               rst_cyc;
        logic               rst_prog;
        logic               en;
    } ctrl_t;

    function automatic logic [CNT_W-1:0] ctrl_image(ctrl_t c);
        logic [CNT_W-1:0] w;
        w = '0;
        w[B_EN]                = c.en;
        w[B_RST_PROG]          = c.rst_prog;
        w[B_RST_CYC]           = c.rst_cyc;
        w[B_DIV]               = c.div;
        w[B_IEN +: NUM_CTR]    = c.ien;
        w[B_OVF +: NUM_CTR]    = c.ovf;
        w[B_SEL1 +: SEL_W]     = c.sel1;
        w[B_SEL0 +: SEL_W]     = c.sel0;
        return w;
    endfunction

    // true when the code selects one of the event input lines
    function automatic logic code_is_line(logic [SEL_W-1:0] code);
        return (int'(code) < NUM_EVT) && (code != CODE_HOLE_A) && (code != CODE_HOLE_B);
    endfunction

endpackage

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel
    import pmu_pkg::*;
(
    input  logic [SEL_W-1:0]   code,
    input  logic [NUM_EVT-1:0] evt_vec,
    input  logic               ext_sig,
    output logic               hit
);

    logic [EIDX_W-1:0] line;
    assign line = code[EIDX_W-1:0];

    always_comb begin
        if (code_is_line(code)) begin
            hit = evt_vec[line];
        end else if (code == CODE_EXT) begin
            hit = ext_sig;
        end else if (code == CODE_CYCLES) begin
            hit = 1'b1;
        end else begin
            hit = 1'b0;
        end
    end

endmodule

// File: rtl/pmu_prescaler.sv
module pmu_prescaler
    import pmu_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);

    logic [W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign tick = run && (phase_q == '1);

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         wrap
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (wr) begin
            cnt <= wdata;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign wrap = inc && !wr && !clr && (cnt == '1);

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr && !clr) |=> cnt == $past(wdata)); // R10

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!inc && !wr && !clr) |=> $stable(cnt)); // R4

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt == '0); // R6

endmodule

// File: rtl/pmu_unit.sv
module pmu_unit
    import pmu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [IDX_W-1:0]   reg_idx,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               ext_sig,
    output logic               irq
);

    ctrl_t              ctrl_q;
    logic [NUM_CTR-1:0] ctr_inc;
    logic [NUM_CTR-1:0] ctr_wr;
    logic [NUM_CTR-1:0] ctr_clr;
    logic [NUM_CTR-1:0] ctr_wrap;
    logic [CNT_W-1:0]   ctr_val [NUM_CTR];
    logic [SEL_W-1:0]   sel_arr [NUM_PRG];
    logic               pre_tick;
    logic               irq_q;
    logic               ctrl_wr;

    assign ctrl_wr    = reg_wr && (reg_idx == REG_CTRL);
    assign sel_arr[0] = ctrl_q.sel0;
    assign sel_arr[1] = ctrl_q.sel1;

    // programmable counters
    generate
        for (genvar g = 0; g < NUM_PRG; g++) begin : g_prog
            localparam reg_idx_e MY_IDX = (g == 0) ? REG_PROG0 : REG_PROG1;
            logic hit;

            pmu_evt_sel u_sel (
                .code    (sel_arr[g]),
                .evt_vec (evt_in),
                .ext_sig (ext_sig),
                .hit     (hit)
            );

            assign ctr_inc[g] = ctrl_q.en && hit;
            assign ctr_wr[g]  = reg_wr && (reg_idx == MY_IDX);
            assign ctr_clr[g] = ctrl_q.rst_prog;

            pmu_counter #(.W(CNT_W)) u_ctr (
                .clk   (clk),
                .rst   (rst),
                .clr   (ctr_clr[g]),
                .wr    (ctr_wr[g]),
                .wdata (reg_wdata),
                .inc   (ctr_inc[g]),
                .cnt   (ctr_val[g]),
                .wrap  (ctr_wrap[g])
            );
        end
    endgenerate

    // dedicated cycle counter
    pmu_prescaler #(.W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctrl_q.rst_cyc),
        .run  (ctrl_q.en),
        .tick (pre_tick)
    );

    assign ctr_inc[SLOT_CYC] = ctrl_q.en && (ctrl_q.div ? pre_tick : 1'b1);
    assign ctr_wr[SLOT_CYC]  = reg_wr && (reg_idx == REG_CYC);
    assign ctr_clr[SLOT_CYC] = ctrl_q.rst_cyc;

    pmu_counter #(.W(CNT_W)) u_cyc (
        .clk   (clk),
        .rst   (rst),
        .clr   (ctr_clr[SLOT_CYC]),
        .wr    (ctr_wr[SLOT_CYC]),
        .wdata (reg_wdata),
        .inc   (ctr_inc[SLOT_CYC]),
        .cnt   (ctr_val[SLOT_CYC]),
        .wrap  (ctr_wrap[SLOT_CYC])
    );

    // control word
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.en       <= reg_wdata[B_EN];
            ctrl_q.rst_prog <= reg_wdata[B_RST_PROG];
            ctrl_q.rst_cyc  <= reg_wdata[B_RST_CYC];
            ctrl_q.div      <= reg_wdata[B_DIV];
            ctrl_q.ien      <= reg_wdata[B_IEN +: NUM_CTR];
            ctrl_q.sel1     <= reg_wdata[B_SEL1 +: SEL_W];
            ctrl_q.sel0     <= reg_wdata[B_SEL0 +: SEL_W];
            ctrl_q.ovf      <= (ctrl_q.ovf & ~reg_wdata[B_OVF +: NUM_CTR]) | ctr_wrap;
        end else begin
            ctrl_q.rst_prog <= 1'b0;
            ctrl_q.rst_cyc  <= 1'b0;
            ctrl_q.ovf      <= ctrl_q.ovf | ctr_wrap;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(ctrl_q.ovf & ctrl_q.ien);
        end
    end

    assign irq = irq_q;

    always_comb begin
        case (reg_idx_e'(reg_idx))
            REG_CTRL:  reg_rdata = ctrl_image(ctrl_q);
            REG_CYC:   reg_rdata = ctr_val[SLOT_CYC];
            REG_PROG0: reg_rdata = ctr_val[0];
            default:   reg_rdata = ctr_val[1];
        endcase
    end

    AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        (|ctr_wrap) |=> (ctrl_q.ovf & $past(ctr_wrap)) == $past(ctr_wrap)); // R7

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(ctrl_q.ovf != '0)); // R8

    AST_PROG_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rst_prog && !(ctrl_wr && reg_wdata[B_RST_PROG])) |=> !ctrl_q.rst_prog); // R9

    AST_CYC_CLR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rst_cyc && !(ctrl_wr && reg_wdata[B_RST_CYC])) |=> !ctrl_q.rst_cyc); // R9

    AST_CLR_ZEROES_PROG: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.rst_prog |=> (ctr_val[0] == '0) && (ctr_val[1] == '0)); // R9

endmodule

// File: tb/pmu_unit_bench.sv
module pmu_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_idx = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [18:0] evt_in = '0;
    logic        ext_sig = 1'b0;
    logic        irq;

    always #5 clk = ~clk;

    pmu_unit u_pmu_unit (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .ext_sig   (ext_sig),
        .irq       (irq)
    );

    int    compared = 0;
    int    mismatched = 0;
    bit    finished = 0;
    string phase = "R1 reset state";

    // behavioural reference model
    bit          m_en, m_div, m_rp, m_rc, m_irq;
    bit [2:0]    m_ien, m_ovf;
    bit [7:0]    m_sel0, m_sel1;
    bit [31:0]   m_cnt [3];   // 0: counter 0, 1: counter 1, 2: cycle counter
    int          m_pre;

    function automatic bit ref_hit(bit [7:0] code);
        if (code <= 8'h12 && code != 8'h08 && code != 8'h0E) return evt_in[code[4:0]];
        if (code == 8'h20) return ext_sig;
        if (code == 8'hFF) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit [31:0] ref_read(bit [1:0] idx);
        case (idx)
            2'd0: return {4'h0, m_sel0, m_sel1, 1'b0, m_ovf, 1'b0, m_ien, m_div, m_rc, m_rp, m_en};
            2'd1: return m_cnt[2];
            2'd2: return m_cnt[0];
            default: return m_cnt[1];
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_div = 0; m_rp = 0; m_rc = 0; m_irq = 0;
            m_ien = 0; m_ovf = 0; m_sel0 = 0; m_sel1 = 0; m_pre = 0;
            for (int k = 0; k < 3; k++) m_cnt[k] = 0;
        end else begin
            bit [2:0]  inc, wrp;
            bit [31:0] nxt [3];
            bit        n_irq;
            int        widx;
            bit        clr;
            inc[0] = m_en && ref_hit(m_sel0);
            inc[1] = m_en && ref_hit(m_sel1);
            inc[2] = m_en && (m_div ? (m_pre == 63) : 1'b1);
            for (int k = 0; k < 3; k++) begin
                widx = (k == 2) ? 1 : k + 2;
                clr  = (k == 2) ? m_rc : m_rp;
                wrp[k] = 0;
                if (clr) nxt[k] = 0;
                else if (reg_wr && reg_idx == widx) nxt[k] = reg_wdata;
                else if (inc[k]) begin
                    wrp[k] = (m_cnt[k] == 32'hFFFF_FFFF);
                    nxt[k] = m_cnt[k] + 1;
                end else nxt[k] = m_cnt[k];
            end
            n_irq = |(m_ovf & m_ien);
            if (m_rc) m_pre = 0;
            else if (m_en) m_pre = (m_pre + 1) % 64;
            if (reg_wr && reg_idx == 0) begin
                m_en = reg_wdata[0]; m_rp = reg_wdata[1]; m_rc = reg_wdata[2];
                m_div = reg_wdata[3]; m_ien = reg_wdata[6:4];
                m_sel1 = reg_wdata[19:12]; m_sel0 = reg_wdata[27:20];
                m_ovf = (m_ovf & ~reg_wdata[10:8]) | wrp;
            end else begin
                m_rp = 0; m_rc = 0;
                m_ovf = m_ovf | wrp;
            end
            for (int k = 0; k < 3; k++) m_cnt[k] = nxt[k];
            m_irq = n_irq;
        end
    end

    task automatic check();
        bit [31:0] exp_rd;
        exp_rd = ref_read(reg_idx);
        compared++;
        if (reg_rdata !== exp_rd) begin
            mismatched++;
            $display("FAIL %s (R11 index %0d) rdata actual=%h expected=%h", phase, reg_idx, reg_rdata, exp_rd);
        end
        compared++;
        if (irq !== m_irq) begin
            mismatched++;
            $display("FAIL %s (R8) irq actual=%0b expected=%0b", phase, irq, m_irq);
        end
    endtask

    bit [31:0] lfsr = 32'h1234_5679;
    bit        evt_on = 0;
    bit        ext_on = 0;
    int        cyc = 0;

    task automatic step(bit wr, bit [1:0] idx, bit [31:0] data);
        @(negedge clk);
        check();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        reg_wr    = wr;
        reg_idx   = idx;
        reg_wdata = data;
        evt_in    = evt_on ? lfsr[18:0] : '0;
        ext_sig   = ext_on ? lfsr[27] : 1'b0;
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'(cyc % 4), 32'h0);
    endtask

    task automatic wr_reg(bit [1:0] idx, bit [31:0] data);
        step(1'b1, idx, data);
    endtask

    function automatic bit [31:0] cw(bit en, bit div, bit [2:0] ien, bit [7:0] s0, bit [7:0] s1);
        return {4'h0, s0, s1, 4'h0, 1'b0, ien, div, 2'b00, en};
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        phase = "R1 reset state";
        run(8);

        phase = "R2 control fields";
        wr_reg(2'd0, 32'hF000_0880 | cw(0, 0, 3'b111, 8'h07, 8'h05));
        run(4);

        phase = "R4 run bit clear";
        evt_on = 1; ext_on = 1;
        run(30);

        phase = "R3 event select lines";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'h07, 8'h05));
        run(60);
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'h00, 8'h0B));
        run(40);
        phase = "R3 external signal and undefined code";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'h20, 8'h08));
        run(40);
        ext_on = 0;
        run(20);
        phase = "R3 cycles code and out-of-range code";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'hFF, 8'h13));
        run(20);
        phase = "R3 top of range and second hole";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'h12, 8'h0E));
        run(40);

        phase = "R10 write priority";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'hFF, 8'h06));
        wr_reg(2'd2, 32'hFFFF_FFF0);
        wr_reg(2'd3, 32'h0);
        run(8);

        phase = "R6 wrap sets flag";
        run(20);

        phase = "R7 flag clear";
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'hFF, 8'h06) | 32'h0000_0100);
        run(4);
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'hFF, 8'h06));
        run(4);
        phase = "R7 set wins over clear";
        wr_reg(2'd2, 32'hFFFF_FFFE);
        run(1);
        wr_reg(2'd0, cw(1, 0, 3'b111, 8'hFF, 8'h06) | 32'h0000_0100);
        run(6);

        phase = "R9 programmable clear strobe";
        wr_reg(2'd0, cw(1, 0, 3'b011, 8'hFF, 8'h06) | 32'h0000_0702);
        run(4);
        phase = "R9 cycle clear strobe";
        wr_reg(2'd0, cw(1, 0, 3'b011, 8'hFF, 8'h06) | 32'h0000_0004);
        run(4);

        phase = "R5 divided cycle counter";
        wr_reg(2'd0, cw(1, 1, 3'b111, 8'hFF, 8'h06) | 32'h0000_0004);
        run(300);

        phase = "R5 cycle counter wrap";
        wr_reg(2'd0, cw(1, 0, 3'b100, 8'h20, 8'h20));
        wr_reg(2'd1, 32'hFFFF_FFF8);
        run(20);

        phase = "R4 hold while stopped";
        wr_reg(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF) | 32'h0000_0700);
        run(20);

        finish_run();
    end

endmodule